// File: doc/BRIEF.md
# Decoded Memory Map for an 8-bit Data / 16-bit Address CPU

This block sits between a small CPU and its memories. It takes the 16-bit address, the active-low memory request strobe and the read/write line (low meaning write), and splits the address space into eight 8K blocks using a 3-to-8 decoder on the top three address lines. Blocks 0 and 1 form the ROM area, block 2 is a reserved hole, and blocks 3 to 7 form the RAM area. Active-low chip selects for each area, and an active-low RAM write enable, come out of the block as ports so that the decode can be observed.

The ROM and RAM are small behavioural models. The ROM content is computed from the address. The RAM is a register array that is smaller than its area, so it aliases throughout the RAM blocks. Reads are combinational and pass through a multiplexer driven by the active chip select. A read from the hole, or any cycle with no request, returns the idle byte FFh. The block has no state machine. Its only state is the RAM array, which is written on the rising clock edge.

Top module: `memmap_subsys`

## Requirements
- R1: `rom_sel_n` is low exactly when `mreq_n` is low and `addr` is in 0000h–3FFFh (decoder outputs 0 and 1).
- R2: `hole_sel_n` is low exactly when `mreq_n` is low and `addr` is in 4000h–5FFFh (decoder output 2).
- R3: `ram_sel_n` is low exactly when `mreq_n` is low and `addr` is in 6000h–FFFFh (decoder outputs 3 to 7). At most one select is low in any cycle.
- R4: While `mreq_n` is high, all three selects and `ram_we_n` are high and `rdata` is FFh.
- R5: `ram_we_n` is low exactly when `ram_sel_n` is low and `rw_n` is low.
- R6: A RAM write stores `wdata` on the rising `clk` edge into word `addr[7:0]`, so every RAM address with the same low byte aliases to it. A later RAM read at any such address returns the stored byte. During a write cycle `rdata` shows the old content.
- R7: A ROM read returns `addr[7:0] ^ {2'b00, addr[13:8]} ^ 8'h3C`.
- R8: A read from the reserved hole returns FFh.
- R9: A write cycle at a ROM or hole address leaves every RAM word unchanged.
- R10: While `rst_n` is low, every RAM word is cleared to 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for RAM writes |
| rst_n | input | 1 | Active-low reset, clears the RAM |
| addr | input | 16 | CPU address bus |
| wdata | input | 8 | CPU write data |
| mreq_n | input | 1 | Active-low memory request |
| rw_n | input | 1 | High for read, low for write |
| rdata | output | 8 | Read data from the selected area |
| rom_sel_n | output | 1 | Active-low ROM area select |
| hole_sel_n | output | 1 | Active-low reserved area select |
| ram_sel_n | output | 1 | Active-low RAM area select |
| ram_we_n | output | 1 | Active-low RAM write enable |

## Verification
The assertions check the select and write-enable relations on every cycle: mutual exclusion of the selects, silence without a request, the write enable only under a RAM select with the write line low, the idle byte for hole reads, and write-then-read coherence on back-to-back cycles. Some behaviours show only over a sequence of cycles, so only the bench's scenarios can demonstrate them: aliasing across RAM blocks, RAM staying untouched after writes aimed at ROM or at the hole, the exact ROM contents at the region edges, and the RAM being cleared by a reset during operation.

// File: rtl/memmap_pkg.sv
package memmap_pkg;
    typedef enum logic [1:0] {
        AREA_NONE = 2'd0,
        AREA_ROM  = 2'd1,
        AREA_HOLE = 2'd2,
        AREA_RAM  = 2'd3
    } area_e;
endpackage

// File: rtl/memmap_dec3to8.sv
module memmap_dec3to8 #(
    parameter int SEL_W = 3,
    localparam int OUTS = 1 << SEL_W
) (
    input  logic             en_n,
    input  logic [SEL_W-1:0] sel,
    output logic [OUTS-1:0]  y_n
);
    for (genvar i = 0; i < OUTS; i++) begin : g_out
        assign y_n[i] = en_n | (sel != SEL_W'(i));
    end
endmodule

// File: rtl/memmap_rom.sv
module memmap_rom #(
    parameter int          OFF_W = 14,
    parameter logic [7:0]  KEY   = 8'h3C
) (
    input  logic [OFF_W-1:0] off,
    output logic [7:0]       dout
);
    logic [OFF_W-1:0] hi_part;
    always_comb begin
        hi_part = off >> 8;
        dout    = off[7:0] ^ hi_part[7:0] ^ KEY;
    end
endmodule

// File: rtl/memmap_ram.sv
module memmap_ram #(
    parameter int AW     = 8,
    parameter int DW     = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          we_n,
    input  logic [AW-1:0] a,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (!cs_n && !we_n) begin
            mem[a] <= din;
        end
    end

    assign dout = mem[a];
endmodule

// File: rtl/memmap_subsys.sv
module memmap_subsys
    import memmap_pkg::*;
#(
    parameter int         ADDR_W    = 16,
    parameter int         DATA_W    = 8,
    parameter int         RAM_AW    = 8,
    parameter logic [7:0] IDLE_BYTE = 8'hFF,
    parameter logic [7:0] ROM_KEY   = 8'h3C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              mreq_n,
    input  logic              rw_n,
    output logic [DATA_W-1:0] rdata,
    output logic              rom_sel_n,
    output logic              hole_sel_n,
    output logic              ram_sel_n,
    output logic              ram_we_n
);
    localparam int BLK_SHIFT = ADDR_W - 3;
    localparam int ROM_OW    = BLK_SHIFT + 1;

    logic [7:0]        blk_n;
    logic [DATA_W-1:0] rom_q;
    logic [DATA_W-1:0] ram_q;
    area_e             area;

    memmap_dec3to8 #(.SEL_W(3)) u_dec (
        .en_n (mreq_n),
        .sel  (addr[ADDR_W-1:BLK_SHIFT]),
        .y_n  (blk_n)
    );

    assign rom_sel_n  = blk_n[0] & blk_n[1];
    assign hole_sel_n = blk_n[2];
    assign ram_sel_n  = &blk_n[7:3];
    assign ram_we_n   = ram_sel_n | rw_n;

    memmap_rom #(.OFF_W(ROM_OW), .KEY(ROM_KEY)) u_rom (
        .off  (addr[ROM_OW-1:0]),
        .dout (rom_q)
    );

    memmap_ram #(.AW(RAM_AW), .DW(DATA_W)) u_ram (
        .clk  (clk),
        .rst_n(rst_n),
        .cs_n (ram_sel_n),
        .we_n (ram_we_n),
        .a    (addr[RAM_AW-1:0]),
        .din  (wdata),
        .dout (ram_q)
    );

    always_comb begin
        area = AREA_NONE;
        if (!rom_sel_n)       area = AREA_ROM;
        else if (!hole_sel_n) area = AREA_HOLE;
        else if (!ram_sel_n)  area = AREA_RAM;
    end

    always_comb begin
        unique case (area)
            AREA_ROM: rdata = rom_q;
            AREA_RAM: rdata = ram_q;
            default:  rdata = DATA_W'(IDLE_BYTE);
        endcase
    end

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~rom_sel_n, ~hole_sel_n, ~ram_sel_n}) <= 1); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        mreq_n |-> (rom_sel_n && hole_sel_n && ram_sel_n && ram_we_n
                    && rdata == DATA_W'(IDLE_BYTE))); // R4
    AST_WE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_we_n |-> (!ram_sel_n && !rw_n && !mreq_n)); // R5
    AST_HOLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !hole_sel_n |-> rdata == DATA_W'(IDLE_BYTE)); // R8
    AST_ROM_SEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_sel_n |-> addr[ADDR_W-1:BLK_SHIFT+1] == 2'b00); // R1
    AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_sel_n && rw_n && $past(rst_n) && !$past(ram_we_n)
         && $past(addr[RAM_AW-1:0]) == addr[RAM_AW-1:0])
        |-> rdata == $past(wdata)); // R6
endmodule

// File: tb/test_memmap_subsys.sv
module test_memmap_subsys;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 17;

    // {mreq_n, rw_n, addr, wdata, rom,hole,ram sel_n, we_n, rdata}
    typedef struct packed {
        logic        mreq_n;
        logic        rw_n;
        logic [15:0] addr;
        logic [7:0]  wdata;
        logic [2:0]  sel_n;
        logic        we_n;
        logic [7:0]  rd;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 1'b1, 16'h0000, 8'h00, 3'b111, 1'b1, 8'hFF}, // R4 idle
        '{1'b0, 1'b1, 16'h0000, 8'h00, 3'b011, 1'b1, 8'h3C}, // R1 R7 rom low edge
        '{1'b0, 1'b1, 16'h3FFF, 8'h00, 3'b011, 1'b1, 8'hFC}, // R1 R7 rom top edge
        '{1'b0, 1'b1, 16'h4000, 8'h00, 3'b101, 1'b1, 8'hFF}, // R2 R8 hole low
        '{1'b0, 1'b1, 16'h5FFF, 8'h00, 3'b101, 1'b1, 8'hFF}, // R2 R8 hole top
        '{1'b0, 1'b1, 16'h6000, 8'h00, 3'b110, 1'b1, 8'h00}, // R3 R10 cleared ram
        '{1'b0, 1'b0, 16'h6005, 8'hA7, 3'b110, 1'b0, 8'h00}, // R5 R6 write, old data
        '{1'b0, 1'b1, 16'h6005, 8'h00, 3'b110, 1'b1, 8'hA7}, // R6 readback
        '{1'b0, 1'b1, 16'hFF05, 8'h00, 3'b110, 1'b1, 8'hA7}, // R6 alias
        '{1'b0, 1'b0, 16'h0005, 8'h55, 3'b011, 1'b1, 8'h39}, // R5 R9 rom write
        '{1'b0, 1'b0, 16'h4005, 8'h66, 3'b101, 1'b1, 8'hFF}, // R5 R9 hole write
        '{1'b0, 1'b1, 16'h6005, 8'h00, 3'b110, 1'b1, 8'hA7}, // R9 ram unchanged
        '{1'b0, 1'b0, 16'hFFFF, 8'h3C, 3'b110, 1'b0, 8'h00}, // R5 R6 top write
        '{1'b0, 1'b1, 16'h60FF, 8'h00, 3'b110, 1'b1, 8'h3C}, // R6 alias read
        '{1'b1, 1'b0, 16'h6010, 8'h99, 3'b111, 1'b1, 8'hFF}, // R4 write w/o request
        '{1'b0, 1'b1, 16'h6010, 8'h00, 3'b110, 1'b1, 8'h00}, // R4 no write happened
        '{1'b0, 1'b1, 16'h1234, 8'h00, 3'b011, 1'b1, 8'h1A}  // R7 rom mid
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        mreq_n = 1'b1;
    logic        rw_n = 1'b1;
    logic [7:0]  rdata;
    logic        rom_sel_n, hole_sel_n, ram_sel_n, ram_we_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    memmap_subsys i_memmap_subsys (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .mreq_n(mreq_n), .rw_n(rw_n), .rdata(rdata),
        .rom_sel_n(rom_sel_n), .hole_sel_n(hole_sel_n),
        .ram_sel_n(ram_sel_n), .ram_we_n(ram_we_n)
    );

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (sel,we,rdata) at addr %h", req, act, exp, addr);
        end
    endtask

    task automatic apply(input vec_t v, input string req);
        @(negedge clk);
        mreq_n = v.mreq_n; rw_n = v.rw_n; addr = v.addr; wdata = v.wdata;
        #1;
        check(req, {rom_sel_n, hole_sel_n, ram_sel_n, ram_we_n, rdata},
                   {v.sel_n, v.we_n, v.rd});
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R10 reset state observed with request on during reset
        #2;
        mreq_n = 1'b0; addr = 16'h6033;
        #1;
        check("R10 reset", {rom_sel_n, hole_sel_n, ram_sel_n, ram_we_n, rdata},
                           {3'b110, 1'b1, 8'h00});
        mreq_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        for (int k = 0; k < NVEC; k++) apply(VECS[k], "R1-vector");

        // R10 reset mid-run clears written word
        apply('{1'b0, 1'b0, 16'h7077, 8'hC3, 3'b110, 1'b0, 8'h00}, "R6 pre-reset write");
        apply('{1'b0, 1'b1, 16'h7077, 8'h00, 3'b110, 1'b1, 8'hC3}, "R6 pre-reset read");
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        apply('{1'b0, 1'b1, 16'h7077, 8'h00, 3'b110, 1'b1, 8'h00}, "R10 cleared");
        apply('{1'b0, 1'b1, 16'h6005, 8'h00, 3'b110, 1'b1, 8'h00}, "R10 cleared alias");

        // R3 boundary just below RAM, R2 edge
        apply('{1'b0, 1'b0, 16'h5FFF, 8'h11, 3'b101, 1'b1, 8'hFF}, "R2 hole top write");
        apply('{1'b0, 1'b1, 16'h60FF, 8'h00, 3'b110, 1'b1, 8'h00}, "R9 hole write no effect");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule